// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Slave with Burst Code Fetch

This block is the memory side of a microcontroller bus whose address and data share pins. A high-active address strobe captures the multiplexed upper address into a latch. Four dedicated pins carry the lowest address bits and are never multiplexed. A mode input, captured once after reset, chooses between a byte-wide bus and a word-wide bus. In byte mode the shared pins carry address bits 11..4. In word mode they carry address bits 19..4.

Code is fetched with its own program-store read strobe from an internal code ROM. Data is read and written through separate read and write strobes to an internal data RAM. The ROM content is a computed pattern. In word mode a high-lane write strobe and a byte-high enable choose which byte lanes are written.

Reads are combinational from the low address pins to the output pins. A burst therefore only needs to step the four low address bits while the latch holds the upper address, with no new address strobe and no extra clock cycles. Write strobes are synchronized to the block clock. A write is committed on the rising edge of its strobe.

Top module: `muxbus_mem_slave`

## Requirements
- R1: After reset no lane is driven (ad_oe_o = 0, ad_o = 0), and every data RAM byte reads as 0.
- R2: While ale_i is high the latch follows ad_i. After ale_i falls the latched value holds, whatever the shared pins do afterwards.
- R3: The byte address is {latch[7:0], addr_lo_i} in byte mode, with bits 19..12 zero and latch[15:8] ignored. It is {latch[15:0], addr_lo_i} in word mode.
- R4: With psen_ni low, the code window 0x00000..0x000FF is read, and the ROM byte at address a equals (a*37+11) mod 256.
- R5: After one address strobe, changing addr_lo_i alone gives the data of each successive location (burst) on the pins immediately.
- R6: A lane is driven only while psen_ni is low with the address in the code window, or rd_ni is low with the address in the data window 0x00400..0x0043F. psen_ni takes priority. Otherwise ad_oe_o = 0 and ad_o = 0.
- R7: In byte mode a read drives ad_o[7:0] with the addressed byte, ad_o[15:8] = 0 and ad_oe_o = 2'b01.
- R8: In word mode a read drives ad_oe_o = 2'b11 and ad_o = {byte[a|1], byte[a&~1]}.
- R9: In byte mode the rising edge of wr_ni writes ad_i[7:0] to the addressed byte. Writes outside the data window change nothing.
- R10: In word mode the rising edge of wr_ni writes ad_i[7:0] to the even byte a&~1 only when a[0] = 0.
- R11: In word mode the rising edge of wrh_ni, or a rising edge of wr_ni while bhe_ni is low, writes ad_i[15:8] to the odd byte a|1.
- R12: mode16_i is captured on the first clock after reset release (1 = word mode). Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | Bus width select, captured after reset (1 = 16-bit) |
| ale_i | input | 1 | Address latch enable, active high |
| psen_ni | input | 1 | Code read strobe, active low |
| rd_ni | input | 1 | Data read strobe, active low |
| wr_ni | input | 1 | Data write strobe (low lane, or both lanes with bhe_ni low), active low |
| wrh_ni | input | 1 | High-lane write strobe in word mode, active low |
| bhe_ni | input | 1 | Byte high enable, active low |
| addr_lo_i | input | 4 | Non-multiplexed address bits 3..0 |
| ad_i | input | 16 | Shared address/data pins, incoming |
| ad_o | output | 16 | Shared address/data pins, outgoing |
| ad_oe_o | output | 2 | Lane drive enables: bit 0 low byte, bit 1 high byte |

## Verification
Every code location is read in both bus widths. In byte mode the upper latched byte is filled with ones, which shows that it is ignored. In word mode the same upper value pushes the address out of the window, which shows that the full latch takes part. A burst walks the low bits downward while the shared pins carry unrelated values. Any dependence on the live pins instead of the latch, or on a stale low address, then shows up. The whole data window is first read as zero after reset, then written with a per-address pattern and read back. A write above the window aliases onto byte 0 if the decode drops the upper bits. The word-mode lane cases cover low-only, high-strobe, byte-high-enable word, odd-address high-only and odd-address with no enable. Together they separate the two high-lane paths from the low-lane alignment rule.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int unsigned ADDR_W = 20;
  typedef logic [ADDR_W-1:0] baddr_t;

  // computed code pattern
  function automatic logic [7:0] rom_byte(input baddr_t a);
    logic [31:0] t;
    t = 32'(a) * 32'd37 + 32'd11;
    return t[7:0];
  endfunction
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/muxbus_ale_latch.sv
module muxbus_ale_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ale_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (ale_i) lat_q <= ad_i;
  end

  // transparent while strobe high
  assign lat_o = ale_i ? ad_i : lat_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i ##1 !ale_i |-> $stable(lat_o));
endmodule

// File: rtl/muxbus_code_rom.sv
module muxbus_code_rom #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] ra_i,
  output logic [15:0]   word_o,
  output logic [7:0]    byte_o
);
  import muxbus_pkg::*;

  logic [AW-1:0] ev_a, od_a;

  assign ev_a   = {ra_i[AW-1:1], 1'b0};
  assign od_a   = {ra_i[AW-1:1], 1'b1};
  assign word_o = {rom_byte(baddr_t'(od_a)), rom_byte(baddr_t'(ev_a))};
  assign byte_o = rom_byte(baddr_t'(ra_i));
endmodule

// File: rtl/muxbus_data_ram.sv
module muxbus_data_ram #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we0_i,
  input  logic [AW-1:0] wa0_i,
  input  logic [7:0]    wd0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] wa1_i,
  input  logic [7:0]    wd1_i,
  input  logic [AW-1:0] ra_i,
  output logic [15:0]   word_o,
  output logic [7:0]    byte_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we0_i) mem_q[wa0_i] <= wd0_i;
      if (we1_i) mem_q[wa1_i] <= wd1_i;
    end
  end

  assign word_o = {mem_q[{ra_i[AW-1:1], 1'b1}], mem_q[{ra_i[AW-1:1], 1'b0}]};
  assign byte_o = mem_q[ra_i];

  // lane mapping must never aim both ports at one byte
  p_lane_distinct_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we0_i && we1_i) |-> (wa0_i != wa1_i));
endmodule

// File: rtl/muxbus_mem_slave.sv
module muxbus_mem_slave #(
  parameter int unsigned CODE_AW     = 8,
  parameter int unsigned DATA_AW     = 6,
  parameter logic [19:0] CODE_BASE   = 20'h00000,
  parameter logic [19:0] DATA_BASE   = 20'h00400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode16_i,
  input  logic        ale_i,
  input  logic        psen_ni,
  input  logic        rd_ni,
  input  logic        wr_ni,
  input  logic        wrh_ni,
  input  logic        bhe_ni,
  input  logic [3:0]  addr_lo_i,
  input  logic [15:0] ad_i,
  output logic [15:0] ad_o,
  output logic [1:0]  ad_oe_o
);
  import muxbus_pkg::*;

  localparam int unsigned DLY_W = 16 + 4 + 1;

  // mode capture
  logic mode16_q, mode_done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode16_q    <= 1'b0;
      mode_done_q <= 1'b0;
    end else if (!mode_done_q) begin
      mode16_q    <= mode16_i;
      mode_done_q <= 1'b1;
    end
  end

  // address latch
  logic [15:0] lat;
  muxbus_ale_latch #(.W(16)) u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ale_i (ale_i),
    .ad_i  (ad_i),
    .lat_o (lat)
  );

  // read path, combinational from low pins
  baddr_t rd_addr;
  logic   code_hit_r, data_hit_r, code_act, data_act, rd_act;
  assign rd_addr    = mode16_q ? {lat, addr_lo_i} : {8'h00, lat[7:0], addr_lo_i};
  assign code_hit_r = rd_addr[ADDR_W-1:CODE_AW] == CODE_BASE[ADDR_W-1:CODE_AW];
  assign data_hit_r = rd_addr[ADDR_W-1:DATA_AW] == DATA_BASE[ADDR_W-1:DATA_AW];
  assign code_act   = mode_done_q && !psen_ni && code_hit_r;
  assign data_act   = mode_done_q && psen_ni && !rd_ni && data_hit_r;
  assign rd_act     = code_act || data_act;

  logic [15:0] rom_word, ram_word;
  logic [7:0]  rom_byte_v, ram_byte;

  muxbus_code_rom #(.AW(CODE_AW)) u_rom (
    .ra_i  (rd_addr[CODE_AW-1:0]),
    .word_o(rom_word),
    .byte_o(rom_byte_v)
  );

  // write path: strobes and pin sample delayed by the same depth
  logic [1:0] stb_s;
  logic [1:0] stb_prev_q;
  muxbus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_stb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wrh_ni, wr_ni}),
    .q_o   (stb_s)
  );

  logic [DLY_W-1:0] dly;
  muxbus_sync #(.W(DLY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ad_i, addr_lo_i, bhe_ni}),
    .q_o   (dly)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_prev_q <= 2'b11;
    else         stb_prev_q <= stb_s;
  end

  logic        wr_rise, wrh_rise, bhe_d;
  logic [15:0] ad_d;
  logic [3:0]  lo_d;
  baddr_t      wr_addr;
  logic        data_hit_w;
  assign wr_rise    = stb_s[0] && !stb_prev_q[0];
  assign wrh_rise   = stb_s[1] && !stb_prev_q[1];
  assign {ad_d, lo_d, bhe_d} = dly;
  assign wr_addr    = mode16_q ? {lat, lo_d} : {8'h00, lat[7:0], lo_d};
  assign data_hit_w = mode_done_q &&
                      (wr_addr[ADDR_W-1:DATA_AW] == DATA_BASE[ADDR_W-1:DATA_AW]);

  logic               we0, we1;
  logic [DATA_AW-1:0] wa0, wa1;
  logic [7:0]         wd0, wd1;
  always_comb begin
    wd0 = ad_d[7:0];
    wd1 = ad_d[15:8];
    if (mode16_q) begin
      we0 = wr_rise && data_hit_w && !wr_addr[0];
      wa0 = {wr_addr[DATA_AW-1:1], 1'b0};
      we1 = (wrh_rise || (wr_rise && !bhe_d)) && data_hit_w;
      wa1 = {wr_addr[DATA_AW-1:1], 1'b1};
    end else begin
      we0 = wr_rise && data_hit_w;
      wa0 = wr_addr[DATA_AW-1:0];
      we1 = 1'b0;
      wa1 = '0;
    end
  end

  muxbus_data_ram #(.AW(DATA_AW)) u_ram (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we0_i (we0),
    .wa0_i (wa0),
    .wd0_i (wd0),
    .we1_i (we1),
    .wa1_i (wa1),
    .wd1_i (wd1),
    .ra_i  (rd_addr[DATA_AW-1:0]),
    .word_o(ram_word),
    .byte_o(ram_byte)
  );

  // pin drive
  always_comb begin
    ad_o    = '0;
    ad_oe_o = 2'b00;
    if (rd_act) begin
      if (mode16_q) begin
        ad_o    = code_act ? rom_word : ram_word;
        ad_oe_o = 2'b11;
      end else begin
        ad_o    = {8'h00, code_act ? rom_byte_v : ram_byte};
        ad_oe_o = 2'b01;
      end
    end
  end

  p_oe_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o != 2'b00) |-> (!psen_ni || !rd_ni));
  p_lane_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode16_q |-> !ad_oe_o[1]);
  p_mode_fixed_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_done_q |=> $stable(mode16_q));
  p_wr_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise |=> !wr_rise);
endmodule

// File: tb/muxbus_mem_slave_tb.sv
module muxbus_mem_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16_i = 1'b0;
  logic        ale_i = 1'b0;
  logic        psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, wrh_n = 1'b1, bhe_n = 1'b1;
  logic [3:0]  addr_lo = '0;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic [1:0]  ad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  muxbus_mem_slave dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .mode16_i (mode16_i),
    .ale_i    (ale_i),
    .psen_ni  (psen_n),
    .rd_ni    (rd_n),
    .wr_ni    (wr_n),
    .wrh_ni   (wrh_n),
    .bhe_ni   (bhe_n),
    .addr_lo_i(addr_lo),
    .ad_i     (ad_i),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe)
  );

  function automatic logic [7:0] exp_rom(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 5 + 1) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m16);
    rst_n = 1'b0;
    mode16_i = m16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ale(input logic [15:0] up);
    @(negedge clk);
    ad_i = up; ale_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ale_i = 1'b0;
    @(negedge clk);
    ad_i = 16'hA5C3;
  endtask

  task automatic rd_bus(input logic code, input logic [3:0] lo,
                        output logic [15:0] d, output logic [1:0] oe);
    @(negedge clk);
    addr_lo = lo;
    if (code) psen_n = 1'b0; else rd_n = 1'b0;
    #1;
    d = ad_o; oe = ad_oe;
    psen_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wr_bus(input logic [3:0] lo, input logic [15:0] data,
                        input logic hi_stb, input logic bhe_low);
    @(negedge clk);
    addr_lo = lo; ad_i = data; bhe_n = !bhe_low;
    if (hi_stb) wrh_n = 1'b0; else wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; wrh_n = 1'b1;
    repeat (4) @(negedge clk);
    bhe_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  oe;

    // ---------- byte mode ----------
    do_reset(1'b0);
    #1;
    check("R1 oe idle", ad_oe, 2'b00);
    check("R1 ad_o idle", ad_o, 16'h0000);
    for (int u = 0; u < 4; u++) begin
      do_ale(16'(16'h0040 + u));
      for (int lo = 0; lo < 16; lo++) begin
        rd_bus(1'b0, 4'(lo), d, oe);
        check("R1 ram zero", d, 16'h0000);
      end
    end

    // R3 R4 R7: upper latched byte ignored in byte mode
    for (int u = 0; u < 16; u++) begin
      do_ale(16'(16'hFF00 | u));
      for (int lo = 0; lo < 16; lo++) begin
        rd_bus(1'b1, 4'(lo), d, oe);
        check("R4 R3 code byte", d, {8'h00, exp_rom(u * 16 + lo)});
        check("R7 oe byte", oe, 2'b01);
      end
    end

    // R5 R2 burst with pins changing underneath
    do_ale(16'h0005);
    for (int lo = 15; lo >= 0; lo--) begin
      ad_i = 16'(lo * 16'h1111);
      rd_bus(1'b1, 4'(lo), d, oe);
      check("R5 R2 burst", d, {8'h00, exp_rom(16'h50 + lo)});
    end

    // R6 window and strobe decode
    do_ale(16'h0020);
    rd_bus(1'b1, 4'd3, d, oe);
    check("R6 code outside oe", oe, 2'b00);
    check("R6 code outside data", d, 16'h0000);
    rd_bus(1'b0, 4'd3, d, oe);
    check("R6 data outside oe", oe, 2'b00);
    do_ale(16'h0040);
    rd_bus(1'b1, 4'd0, d, oe);
    check("R6 psen in data window", oe, 2'b00);
    do_ale(16'h0001);
    rd_bus(1'b0, 4'd0, d, oe);
    check("R6 rd in code window", oe, 2'b00);

    // R9 byte writes over the whole window
    for (int u = 0; u < 4; u++) begin
      do_ale(16'(16'h0040 + u));
      for (int lo = 0; lo < 16; lo++) wr_bus(4'(lo), {8'hEE, pat(u * 16 + lo)}, 1'b0, 1'b0);
    end
    do_ale(16'h0044);
    wr_bus(4'd0, 16'h00FF, 1'b0, 1'b0);
    for (int u = 0; u < 4; u++) begin
      do_ale(16'(16'h0040 + u));
      for (int lo = 0; lo < 16; lo++) begin
        rd_bus(1'b0, 4'(lo), d, oe);
        check("R9 ram readback", d, {8'h00, pat(u * 16 + lo)});
      end
    end

    // R12 mode input change without reset ignored
    mode16_i = 1'b1;
    do_ale(16'h0003);
    rd_bus(1'b1, 4'd0, d, oe);
    check("R12 still byte data", d, {8'h00, exp_rom(16'h30)});
    check("R12 still byte oe", oe, 2'b01);

    // ---------- word mode ----------
    do_reset(1'b1);
    do_ale(16'h0040);
    rd_bus(1'b0, 4'd0, d, oe);
    check("R1 ram cleared", d, 16'h0000);
    for (int u = 0; u < 16; u++) begin
      do_ale(16'(u));
      for (int lo = 0; lo < 16; lo++) begin
        rd_bus(1'b1, 4'(lo), d, oe);
        check("R8 code word", d,
              {exp_rom((u * 16 + lo) | 1), exp_rom((u * 16 + lo) & ~1)});
        check("R8 oe word", oe, 2'b11);
      end
    end
    do_ale(16'hFF00);
    rd_bus(1'b1, 4'd0, d, oe);
    check("R3 upper used in word mode", oe, 2'b00);

    do_ale(16'h0040);
    wr_bus(4'd2, 16'hBEEF, 1'b0, 1'b0);
    rd_bus(1'b0, 4'd2, d, oe);
    check("R10 low lane only", d, 16'h00EF);
    wr_bus(4'd2, 16'h1234, 1'b1, 1'b0);
    rd_bus(1'b0, 4'd2, d, oe);
    check("R11 high strobe", d, 16'h12EF);
    wr_bus(4'd4, 16'h5678, 1'b0, 1'b1);
    rd_bus(1'b0, 4'd4, d, oe);
    check("R11 bhe word write", d, 16'h5678);
    wr_bus(4'd7, 16'h9ABC, 1'b0, 1'b1);
    rd_bus(1'b0, 4'd6, d, oe);
    check("R11 odd high only", d, 16'h9A00);
    wr_bus(4'd9, 16'h4321, 1'b0, 1'b0);
    rd_bus(1'b0, 4'd8, d, oe);
    check("R10 odd no enable", d, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule